// File: doc/BRIEF.md
# Serial Register Write Interface

This block is the configuration port of an analog front-end. A host drives three pins: an active-low select, a serial clock and a serial data line. While select is low, every rising edge of the serial clock shifts one data bit in, most significant bit first. Each group of 24 bits forms one word: an 8-bit register address followed by 16 data bits. On the 24th rising edge of each group the data lands in the addressed register. One select-low period may carry any number of words back to back, and a trailing group shorter than 24 bits is dropped.

The pins are brought into the system clock domain through a synchronizer, and serial clock edges are found by comparing successive samples. The serial clock may therefore run at any rate up to a few tens of MHz, with any duty cycle, as long as each level lasts long enough for the system clock to see it. The register contents leave the block as one flat vector that the analog circuits decode. Bit 0 of register 0 switches the port into a diagnostic readout mode. In that mode the addressed register is shifted out on a serial output during the data half of each word, and writes are suppressed except to register 0, so the host can always leave the mode again.

The port has no flow control. It cannot stall the host: every serial clock edge seen while select is low is consumed, and a register write takes effect a few system clock cycles after the edge that completes the word.

Top module: `cfg_serial_port`

## Requirements
- R1: A synchronous reset (rst high at a clk edge) sets every register to 0x0000, clears the bit counter and drives sdo low.
- R2: While sel_n is low, sdi is sampled on each rising edge of sclk. The first bit is word bit 23, bits 23:16 are the address and bits 15:0 are the data. Register k appears on reg_q[16k+15:16k].
- R3: A register write commits only on the 24th sclk rising edge counted from the falling edge of sel_n (and on each further 24th edge). No edge before that changes any register.
- R4: Several complete words sent back to back within one sel_n low period are each written to their own addresses.
- R5: When sel_n rises after a partial group of fewer than 24 bits, those bits cause no write.
- R6: Raising sel_n clears the bit counter, so the next low period starts a new word. sclk edges while sel_n is high have no effect.
- R7: Words whose address is 16 or higher write nothing, and in readout mode such an address reads out as zero.
- R8: With register 0 bit 0 set at the start of a word, sdo presents the addressed register MSB first: register bit 15-j is valid before rising edge 9+j of that word. sdo is low during the address bits and whenever the port is not in a readout data phase.
- R9: In readout mode a word to any address other than 0 writes nothing. A word to address 0 is still written, and its effect on the mode begins with the next word.
- R10: An sclk rising edge that reaches the port in the same system clock cycle as the release of sel_n is discarded, so a 24th edge that arrives together with the release commits nothing.
- R11: Any duty cycle is accepted as long as each sclk high and low level lasts at least 3 clk cycles, since the pins pass through a 2-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial readout data to the host |
| reg_q | output | NREG*DATA_W | Flat image of all registers, register k at bits 16k+15:16k |

## Verification
Two events can meet in one system clock cycle: the serial clock edge that completes a word (which commits a write) and the release of select (which clears the counter and aborts the word). The bench provokes this by raising sclk and sel_n on the same clk edge for the 24th bit, so both arrive through the synchronizer together. It judges the outcome by the register image, which must not change: the scoreboard monitor reports any register change that no queued expectation accounts for. A second overlap is a write to register 0 in the same word that is being read out. The bench checks that the mode change only affects the following word.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int DEF_ADDR_W = 8;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_NREG   = 16;
  localparam int DEF_SYNC   = 2;

  typedef enum logic {
    RO_OFF = 1'b0,
    RO_ON  = 1'b1
  } ro_state_e;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[CHAIN_W-W-1:0], d};
      end
    end
  endgenerate

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/cfgp_frame.sv
module cfgp_frame #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int WORD_W = ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_act,
  input  logic              rise,
  input  logic              sdi,
  output logic [CNT_W-1:0]  cnt,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              addr_stb,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              data_shift
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_BEG = CNT_W'(ADDR_W);

  logic [WORD_W-2:0] shreg;
  logic [WORD_W-1:0] word_q;
  logic              take;

  assign take = sel_act & rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      shreg    <= '0;
      word_q   <= '0;
      wr_stb   <= 1'b0;
      addr_stb <= 1'b0;
    end else begin
      wr_stb   <= 1'b0;
      addr_stb <= 1'b0;
      if (!sel_act) begin
        cnt <= '0;
      end else if (take) begin
        shreg <= {shreg[WORD_W-3:0], sdi};
        if (cnt == ADDR_END) addr_stb <= 1'b1;
        if (cnt == LAST_BIT) begin
          cnt    <= '0;
          wr_stb <= 1'b1;
          word_q <= {shreg, sdi};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign wr_addr    = word_q[WORD_W-1 -: ADDR_W];
  assign wr_data    = word_q[DATA_W-1:0];
  assign rd_addr    = shreg[ADDR_W-1:0];
  assign data_shift = take & (cnt >= DATA_BEG);
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int NREG = 16,
  parameter int RO_BIT = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_stb,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   ro_en,
  output logic [NREG*DATA_W-1:0] reg_q
);
  generate
    for (genvar k = 0; k < NREG; k++) begin : g_reg
      logic [DATA_W-1:0] r;
      logic              hit;
      // register 0 stays writable in readout mode so the mode can be left
      assign hit = wr_stb && (wr_addr == ADDR_W'(k)) && ((k == 0) || !ro_en);
      always_ff @(posedge clk) begin
        if (rst)      r <= '0;
        else if (hit) r <= wr_data;
      end
      assign reg_q[k*DATA_W +: DATA_W] = r;
    end
  endgenerate

  assign ro_en = reg_q[RO_BIT];

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++) begin
      if (rd_addr == ADDR_W'(k)) rd_data = reg_q[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/cfgp_readout.sv
module cfgp_readout
  import cfgp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_act,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  input  logic              done,
  output logic              sdo
);
  ro_state_e         st;
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || !sel_act) begin
      st <= RO_OFF;
      sh <= '0;
    end else if (load) begin
      st <= RO_ON;
      sh <= load_data;
    end else if (done) begin
      st <= RO_OFF;
    end else if (st == RO_ON && shift) begin
      sh <= {sh[DATA_W-2:0], 1'b0};
    end
  end

  assign sdo = (st == RO_ON) && sh[DATA_W-1];
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgp_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int NREG = DEF_NREG,
  parameter int SYNC_STAGES = DEF_SYNC,
  parameter int RO_BIT = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sel_n,
  input  logic                   sclk,
  input  logic                   sdi,
  output logic                   sdo,
  output logic [NREG*DATA_W-1:0] reg_q
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(WORD_W);

  logic [2:0]        pins_s;
  logic              sel_act, sclk_s, sdi_s, sclk_p, rise;
  logic [CNT_W-1:0]  cnt;
  logic              wr_stb, addr_stb, data_shift, ro_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  cfgp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({sel_n, sclk, sdi}), .q(pins_s)
  );

  assign sel_act = ~pins_s[2];
  assign sclk_s  = pins_s[1];
  assign sdi_s   = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) sclk_p <= 1'b0;
    else     sclk_p <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_p;

  cfgp_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .sel_act(sel_act), .rise(rise), .sdi(sdi_s),
    .cnt(cnt), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .addr_stb(addr_stb), .rd_addr(rd_addr), .data_shift(data_shift)
  );

  cfgp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .RO_BIT(RO_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ro_en(ro_en), .reg_q(reg_q)
  );

  cfgp_readout #(.DATA_W(DATA_W)) u_ro (
    .clk(clk), .rst(rst), .sel_act(sel_act), .load(addr_stb & ro_en),
    .load_data(rd_data), .shift(data_shift), .done(wr_stb), .sdo(sdo)
  );
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int NREG = 16,
  localparam int WORD_W = ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   sel_act,
  input logic                   rise,
  input logic [CNT_W-1:0]       cnt,
  input logic                   wr_stb,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic                   ro_en,
  input logic [NREG*DATA_W-1:0] reg_q,
  input logic                   sdo
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_BIT);

  p_commit_at_last_r3: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (cnt == '0) && ($past(cnt) == LAST_BIT));

  p_release_clears_r6: assert property (@(posedge clk) disable iff (rst)
    !sel_act |=> cnt == '0);

  p_no_stray_write_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(reg_q));

  p_ro_suppress_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && ro_en && wr_addr != '0) |=> $stable(reg_q));

  p_sdo_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !sel_act |=> !sdo);

  p_abort_edge_r10: assert property (@(posedge clk) disable iff (rst)
    (rise && !sel_act) |=> !wr_stb);
endmodule

bind cfg_serial_port cfg_serial_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)
) u_chk (
  .clk(clk), .rst(rst), .sel_act(sel_act), .rise(rise), .cnt(cnt),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .ro_en(ro_en), .reg_q(reg_q), .sdo(sdo)
);

// File: tb/cfg_serial_port_test.sv
`timescale 1ns/1ps
module cfg_serial_port_test;
  localparam int NR = 16;
  localparam int DW = 16;
  localparam int IW = NR * DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [IW-1:0] reg_q;

  always #4 clk = ~clk;

  cfg_serial_port #(.NREG(NR)) uut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .reg_q(reg_q)
  );

  typedef struct { int addr; logic [DW-1:0] data; } exp_t;
  exp_t exp_q[$];
  logic [DW-1:0] model [NR];
  int total = 0, bad = 0;
  bit finished = 0;
  logic [IW-1:0] prev;

  task automatic chk(input bit ok, input string tag, input logic [IW-1:0] act,
                     input logic [IW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] image();
    logic [IW-1:0] v;
    for (int k = 0; k < NR; k++) v[k*DW +: DW] = model[k];
    return v;
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard driver side: predict the write a word will cause
  task automatic predict(input int a, input logic [DW-1:0] d);
    if (a < NR && (!model[0][0] || a == 0) && model[a] != d) begin
      exp_t e;
      e.addr = a; e.data = d;
      exp_q.push_back(e);
      model[a] = d;
    end
  endtask

  task automatic bits(input int a, input logic [DW-1:0] d, input int lo, input int hi,
                      output logic [DW-1:0] cap, output bit hi_zero);
    logic [23:0] w;
    w = {a[7:0], d};
    hi_zero = 1'b1;
    cap = '0;
    for (int b = 23; b >= 0; b--) begin
      sdi = w[b]; sclk = 1'b0;
      waitc(lo);
      if (b <= 15) cap[b] = sdo;
      else if (sdo !== 1'b0) hi_zero = 1'b0;
      sclk = 1'b1;
      waitc(hi);
    end
  endtask

  task automatic word(input int a, input logic [DW-1:0] d);
    logic [DW-1:0] c; bit z;
    predict(a, d);
    bits(a, d, 4, 4, c, z);
  endtask

  task automatic sel_on();
    sclk = 1'b0; sel_n = 1'b0; waitc(4);
  endtask

  task automatic sel_off();
    sclk = 1'b0; waitc(3); sel_n = 1'b1; waitc(8);
  endtask

  task automatic do_reset();
    rst = 1'b1; waitc(4);
    for (int k = 0; k < NR; k++) model[k] = '0;
    exp_q.delete();
    rst = 1'b0; waitc(2);
  endtask

  // scoreboard monitor: every change of the register image must match a queued write
  always @(negedge clk) begin
    if (rst) prev = reg_q;
    else if (reg_q !== prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5/R7/R9 unexpected register change", reg_q, prev);
      end else begin
        exp_t e;
        logic [IW-1:0] want;
        e = exp_q.pop_front();
        want = prev;
        want[e.addr*DW +: DW] = e.data;
        chk(reg_q === want, "R3 committed write content", reg_q, want);
      end
      prev = reg_q;
    end
  end

  initial begin
    logic [DW-1:0] cap; bit z;
    logic [IW-1:0] snap;
    for (int k = 0; k < NR; k++) model[k] = '0;
    waitc(5);
    rst = 1'b0; waitc(3);

    // R1 reset state
    chk(reg_q === '0, "R1 registers zero after reset", reg_q, '0);
    chk(sdo === 1'b0, "R1 sdo low after reset", IW'(sdo), '0);

    // R2 R3 single word
    sel_on(); word(3, 16'hA5C3); sel_off();
    chk(reg_q[3*DW +: DW] === 16'hA5C3, "R2 single word addr 3",
        IW'(reg_q[3*DW +: DW]), IW'(16'hA5C3));

    // R4 back to back words in one select
    sel_on(); word(1, 16'h1234); word(15, 16'hFFFF); word(7, 16'h8001); sel_off();
    chk(reg_q === image(), "R4 three words one select", reg_q, image());

    // R5 trailing partial word
    sel_on(); word(2, 16'h0F0F);
    snap = image();
    for (int b = 0; b < 10; b++) begin
      sdi = b[0]; sclk = 1'b0; waitc(4); sclk = 1'b1; waitc(4);
    end
    sel_off();
    chk(reg_q === snap, "R5 partial group discarded", reg_q, snap);

    // R6 release mid word, then sclk toggles while released
    sel_on();
    for (int b = 0; b < 12; b++) begin
      sdi = 1'b1; sclk = 1'b0; waitc(4); sclk = 1'b1; waitc(4);
    end
    sel_off();
    for (int b = 0; b < 30; b++) begin
      sdi = b[1]; sclk = 1'b1; waitc(4); sclk = 1'b0; waitc(4);
    end
    sel_on(); word(5, 16'hBEEF); sel_off();
    chk(reg_q === image(), "R6 counter cleared by release", reg_q, image());

    // R7 out of range address
    snap = reg_q;
    sel_on(); word(20, 16'hDEAD); word(255, 16'h5555); sel_off();
    chk(reg_q === snap, "R7 out of range address ignored", reg_q, snap);

    // R11 uneven duty: short high, long low
    sel_on(); predict(9, 16'h3C3C); bits(9, 16'h3C3C, 21, 3, cap, z); sel_off();
    chk(reg_q[9*DW +: DW] === 16'h3C3C, "R11 uneven duty write",
        IW'(reg_q[9*DW +: DW]), IW'(16'h3C3C));

    // R8 R9 readout
    sel_on(); word(0, 16'h0001);
    predict(3, 16'h0000); bits(3, 16'h0000, 4, 4, cap, z);
    chk(cap === 16'hA5C3, "R8 readout of register 3", IW'(cap), IW'(16'hA5C3));
    chk(z, "R8 sdo low during address bits", IW'(!z), '0);
    predict(20, 16'hFFFF); bits(20, 16'hFFFF, 4, 4, cap, z);
    chk(cap === 16'h0000, "R7 out of range reads zero", IW'(cap), '0);
    predict(15, 16'h0000); bits(15, 16'h0000, 4, 4, cap, z);
    chk(cap === 16'hFFFF, "R8 readout of register 15", IW'(cap), IW'(16'hFFFF));
    sel_off();
    chk(reg_q[3*DW +: DW] === 16'hA5C3, "R9 write suppressed in readout",
        IW'(reg_q[3*DW +: DW]), IW'(16'hA5C3));
    chk(sdo === 1'b0, "R8 sdo low after release", IW'(sdo), '0);
    sel_on(); word(0, 16'h0000); word(3, 16'h7E81); sel_off();
    chk(reg_q[3*DW +: DW] === 16'h7E81, "R9 address 0 leaves readout",
        IW'(reg_q[3*DW +: DW]), IW'(16'h7E81));
    chk(reg_q[0 +: DW] === 16'h0000, "R9 register 0 written in readout",
        IW'(reg_q[0 +: DW]), '0);

    // R10 24th edge together with release
    snap = reg_q;
    sel_on();
    begin
      logic [23:0] w;
      w = {8'd4, 16'h9999};
      for (int b = 23; b >= 1; b--) begin
        sdi = w[b]; sclk = 1'b0; waitc(4); sclk = 1'b1; waitc(4);
      end
      sdi = w[0]; sclk = 1'b0; waitc(4);
      sclk = 1'b1; sel_n = 1'b1; waitc(8);
      sclk = 1'b0; waitc(8);
    end
    chk(reg_q === snap, "R10 edge with release commits nothing", reg_q, snap);

    // R1 reset in the middle of a word
    sel_on();
    for (int b = 0; b < 9; b++) begin
      sdi = 1'b1; sclk = 1'b0; waitc(4); sclk = 1'b1; waitc(4);
    end
    sclk = 1'b0; sel_n = 1'b1;
    do_reset();
    chk(reg_q === '0, "R1 reset clears registers", reg_q, '0);
    sel_on(); word(6, 16'h0042); sel_off();
    chk(reg_q === image(), "R1 clean word after reset", reg_q, image());

    waitc(20);
    chk(exp_q.size() == 0, "R3 every predicted write seen", IW'(exp_q.size()), '0);
    chk(reg_q === image(), "R3 final register image", reg_q, image());
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule